// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register front end of a serial port. It decodes a small read/write bus that carries a byte offset into a 4 KiB window. It holds a receive byte queue, which an external receive path fills one byte at a time, and it presents transmit bytes as single-cycle strobes for a serializer that lives outside the block.

Accesses to the data register have side effects. A read takes the oldest received byte off the queue. A write sends a byte out and raises the transmit interrupt status. One offset is a receive status register on read and an error-clear register on write.

The block also keeps these registers as plain storage:
- the baud divisors
- line control and control
- FIFO level select
- DMA control
- IrDA

The interrupt logic holds a raw status word, a mask, a masked view and a write-one-to-clear port, and drives one level interrupt line. A fixed identification signature sits at the top of the window.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the flag register (0x18) reads 0x90 (transmit-empty bit 7 and receive-empty bit 4 set), raw status (0x3C) and masked status (0x40) read 0, and `irq` is low.
- R2: A read of the data register (0x00) returns the queued bytes oldest first in bits 7:0. A read with an empty queue returns 0 and changes no state.
- R3: An arriving byte sets raw status bit 4 and clears flag bit 4. A data read that empties the queue clears raw status bit 4 and sets flag bit 4.
- R4: A write of the data register pulses `tx_valid` high for exactly one cycle, with `tx_byte` equal to write-data bits 7:0, and sets raw status bit 5. Flag bit 7 stays set.
- R5: Masked status (0x40) reads raw status AND mask (0x38). `irq` is high exactly while that AND is nonzero, and it follows each access or receive event on the next clock edge.
- R6: Writing the clear register (0x44) clears each raw status bit written as 1 and leaves the others. A read of 0x44 returns 0.
- R7: Flag bit 6 is set while the queue holds RXQ_DEPTH bytes. A byte that arrives at a full queue, with no pop in the same cycle, is dropped. The drop sets raw status bit 10 and bit 3 of receive status (0x04). A write to 0x04 zeroes receive status.
- R8: The storage registers keep only these bits, and everything above reads 0:
  - IrDA 0x20: 8 bits
  - integer baud 0x24: 16 bits
  - fractional baud 0x28: 6 bits
  - line control 0x2C: 8 bits
  - control 0x30: 16 bits
  - level select 0x34: 6 bits
  - mask 0x38: 11 bits
  - DMA control 0x48: 3 bits
- R9: Offsets 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8, 0xFFC read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Writes to the flag, raw status and masked status registers are ignored. Unmapped or misaligned offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the clock edge |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt, high while any masked status bit is set |

## Verification
The bench builds the block with RXQ_DEPTH set to 4. With that depth, the full flag, the drop of a fifth byte and the overrun flags can be reached after only a handful of receive strobes. The same drain then shows that the dropped byte never reaches the data register. All other parameters keep their defaults, so the register widths and identification values under test are the ones a chip would see.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int RXQ_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  localparam int PW = (RXQ_DEPTH > 1) ? $clog2(RXQ_DEPTH) : 1;
  localparam int CW = $clog2(RXQ_DEPTH + 1);

  localparam logic [11:0] A_DATA = 12'h000, A_RSTAT = 12'h004, A_FLAG = 12'h018,
    A_IRDA = 12'h020, A_BAUDI = 12'h024, A_BAUDF = 12'h028, A_LINE = 12'h02C,
    A_CTRL = 12'h030, A_LVL = 12'h034, A_MASK = 12'h038, A_RAW = 12'h03C,
    A_MSK = 12'h040, A_CLR = 12'h044, A_DMA = 12'h048;

  logic [7:0]    rxq [RXQ_DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, cnt_n;
  logic [10:0]   raw, raw_n, mask;
  logic [3:0]    rstat;
  logic [7:0]    irda_r, line_r;
  logic [15:0]   baudi_r, ctrl_r;
  logic [5:0]    baudf_r, lvl_r;
  logic [2:0]    dma_r;
  logic [31:0]   rd_val;

  wire wr_hit_data = bus_wr && bus_addr == A_DATA;
  wire q_empty = cnt == '0;
  wire q_full  = cnt == CW'(RXQ_DEPTH);
  wire pop     = bus_rd && bus_addr == A_DATA && !q_empty;
  wire push    = rx_valid && (!q_full || pop);
  wire drop    = rx_valid && !push;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(RXQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cnt_n = cnt + CW'(push) - CW'(pop);
  assign irq = |(raw & mask);

  always_ff @(posedge clk)
    if (push) rxq[wr_ptr] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop)  rd_ptr <= step(rd_ptr);
      if (push) wr_ptr <= step(wr_ptr);
      cnt <= cnt_n;
    end

  always_comb begin
    raw_n = raw;
    if (bus_wr && bus_addr == A_CLR) raw_n = raw_n & ~bus_wdata[10:0];
    if (pop && cnt_n == '0)          raw_n[4] = 1'b0;
    if (push)                        raw_n[4] = 1'b1;
    if (wr_hit_data)                 raw_n[5] = 1'b1;
    if (drop)                        raw_n[10] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      raw <= '0; mask <= '0; rstat <= '0;
      irda_r <= '0; line_r <= '0; baudi_r <= '0; ctrl_r <= '0;
      baudf_r <= '0; lvl_r <= '0; dma_r <= '0;
      tx_valid <= 1'b0; tx_byte <= '0;
    end else begin
      raw <= raw_n;
      tx_valid <= wr_hit_data;
      if (wr_hit_data) tx_byte <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_RSTAT) rstat <= '0;
      if (drop) rstat[3] <= 1'b1;
      if (bus_wr)
        case (bus_addr)
          A_IRDA:  irda_r  <= bus_wdata[7:0];
          A_BAUDI: baudi_r <= bus_wdata[15:0];
          A_BAUDF: baudf_r <= bus_wdata[5:0];
          A_LINE:  line_r  <= bus_wdata[7:0];
          A_CTRL:  ctrl_r  <= bus_wdata[15:0];
          A_LVL:   lvl_r   <= bus_wdata[5:0];
          A_MASK:  mask    <= bus_wdata[10:0];
          A_DMA:   dma_r   <= bus_wdata[2:0];
          default: ;
        endcase
    end

  always_comb
    case (bus_addr)
      A_DATA:  rd_val = q_empty ? '0 : {24'h0, rxq[rd_ptr]};
      A_RSTAT: rd_val = {28'h0, rstat};
      A_FLAG:  rd_val = {23'h0, 1'b0, 1'b1, q_full, 1'b0, q_empty, 4'h0};
      A_IRDA:  rd_val = {24'h0, irda_r};
      A_BAUDI: rd_val = {16'h0, baudi_r};
      A_BAUDF: rd_val = {26'h0, baudf_r};
      A_LINE:  rd_val = {24'h0, line_r};
      A_CTRL:  rd_val = {16'h0, ctrl_r};
      A_LVL:   rd_val = {26'h0, lvl_r};
      A_MASK:  rd_val = {21'h0, mask};
      A_RAW:   rd_val = {21'h0, raw};
      A_MSK:   rd_val = {21'h0, raw & mask};
      A_DMA:   rd_val = {29'h0, dma_r};
      12'hFE0: rd_val = 32'h11;
      12'hFE4: rd_val = 32'h10;
      12'hFE8: rd_val = 32'h14;
      12'hFEC: rd_val = 32'h00;
      12'hFF0: rd_val = 32'h0D;
      12'hFF4: rd_val = 32'hF0;
      12'hFF8: rd_val = 32'h05;
      12'hFFC: rd_val = 32'hB1;
      default: rd_val = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_data |=> tx_valid && tx_byte == $past(bus_wdata[7:0])); // R4
  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_data |=> !tx_valid); // R4
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_DATA && q_empty |=> bus_rdata == 32'h0 && $stable(rd_ptr)); // R2
  AST_RX_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> raw[4] && cnt != '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(RXQ_DEPTH)); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> raw[10] && rstat[3] && $stable(cnt)); // R7
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_MASK && bus_wdata[10:0] == 11'h0 |=> !irq); // R5
endmodule

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0, rx_valid = 0;
  logic [7:0] rx_byte = '0;
  logic [31:0] bus_rdata;
  logic tx_valid, irq;
  logic [7:0] tx_byte;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regfile #(.RXQ_DEPTH(4)) u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 flags", 12'h018, 32'h90);
    rd_chk("R1 raw", 12'h03C, 32'h0);
    rd_chk("R1 masked", 12'h040, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ids();
    logic [31:0] exp [8] = '{32'h11, 32'h10, 32'h14, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};
    for (int i = 0; i < 8; i++) rd_chk("R9 id", 12'hFE0 + 12'(4 * i), exp[i]);
  endtask

  task automatic t_storage();
    logic [11:0] adr [8] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h038, 12'h048};
    logic [31:0] msk [8] = '{32'hFF, 32'hFFFF, 32'h3F, 32'hFF, 32'hFFFF, 32'h3F, 32'h7FF, 32'h7};
    for (int i = 0; i < 8; i++) begin
      wr(adr[i], 32'hFFFF_FFFF);
      rd_chk("R8 width", adr[i], msk[i]);
    end
    wr(12'h038, 32'h0);
    rd_chk("R8 mask cleared", 12'h038, 32'h0);
  endtask

  task automatic t_rx();
    rx(8'hA1); rx(8'hB2); rx(8'hC3);
    rd_chk("R3 not empty", 12'h018, 32'h80);
    rd_chk("R3 raw rx", 12'h03C, 32'h10);
    rd_chk("R2 first", 12'h000, 32'hA1);
    rd_chk("R2 second", 12'h000, 32'hB2);
    rd_chk("R3 raw kept", 12'h03C, 32'h10);
    rd_chk("R2 third", 12'h000, 32'hC3);
    rd_chk("R3 raw cleared", 12'h03C, 32'h0);
    rd_chk("R3 empty again", 12'h018, 32'h90);
    rd_chk("R2 empty read", 12'h000, 32'h0);
    rd_chk("R2 empty no change", 12'h018, 32'h90);
  endtask

  task automatic t_tx();
    wr(12'h000, 32'h1234_565A);
    check("R4 tx_valid", {31'h0, tx_valid}, 32'h1);
    check("R4 tx_byte", {24'h0, tx_byte}, 32'h5A);
    @(negedge clk);
    check("R4 single pulse", {31'h0, tx_valid}, 32'h0);
    rd_chk("R4 raw tx", 12'h03C, 32'h20);
    rd_chk("R4 tx empty", 12'h018, 32'h90);
  endtask

  task automatic t_irq();
    check("R5 masked off", {31'h0, irq}, 32'h0);
    wr(12'h038, 32'h20);
    check("R5 irq on", {31'h0, irq}, 32'h1);
    rd_chk("R5 masked", 12'h040, 32'h20);
    wr(12'h038, 32'h10);
    check("R5 other mask", {31'h0, irq}, 32'h0);
    rd_chk("R5 masked zero", 12'h040, 32'h0);
    rx(8'h77);
    check("R5 rx irq", {31'h0, irq}, 32'h1);
    wr(12'h044, 32'h20);
    rd_chk("R6 clear one bit", 12'h03C, 32'h10);
    rd_chk("R6 clear reads 0", 12'h044, 32'h0);
    rd_chk("R2 drain", 12'h000, 32'h77);
    check("R5 irq off", {31'h0, irq}, 32'h0);
    wr(12'h038, 32'h0);
  endtask

  task automatic t_full();
    rx(8'h01); rx(8'h02); rx(8'h03); rx(8'h04);
    rd_chk("R7 full flag", 12'h018, 32'hC0);
    rx(8'hEE);
    rd_chk("R7 overrun raw", 12'h03C, 32'h410);
    rd_chk("R7 rx status", 12'h004, 32'h8);
    wr(12'h004, 32'h0);
    rd_chk("R7 status cleared", 12'h004, 32'h0);
    for (int i = 1; i <= 4; i++) rd_chk("R7 kept byte", 12'h000, 32'(i));
    rd_chk("R7 dropped byte gone", 12'h000, 32'h0);
    wr(12'h044, 32'h7FF);
    rd_chk("R6 clear all", 12'h03C, 32'h0);
  endtask

  task automatic t_ignored();
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h03C, 32'hFFFF_FFFF);
    wr(12'h040, 32'hFFFF_FFFF);
    rd_chk("R10 flags", 12'h018, 32'h90);
    rd_chk("R10 raw", 12'h03C, 32'h0);
    rd_chk("R10 masked", 12'h040, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h026, 32'h0);
    rd_chk("R10 unmapped", 12'h100, 32'h0);
    rd_chk("R10 misaligned", 12'h026, 32'h0);
    rd_chk("R10 baud intact", 12'h024, 32'hFFFF);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_storage();
    t_rx();
    t_tx();
    t_irq();
    t_full();
    t_ignored();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end
endmodule